// File: doc/BRIEF.md
# System Clock Source Switch and Bus Prescaler

This block decides which of three clock sources drives the system and how fast the bus runs relative to it. Software writes a two-bit source choice (internal oscillator, external oscillator or PLL) and a four-bit bus divide code through a single write strobe. The block keeps both written values and reports them. It also reports which source is actually in use. That report moves to the requested source only once that source signals that it is ready.

Two hardware events override the software choice and return the system to the internal oscillator. The first is a pulse marking the exit from a low-power state. The second is a failure of the external oscillator while it is clocking the system, either on its own or as the reference of the PLL. The oscillators and any glitch-free analog muxing are outside this block. Sources are represented only by their ready inputs. The divided bus clock is represented by a clock-enable strobe. Every pin is a plain control or status pin, and no interface here carries a data stream.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, `sel_src` = 00, `act_src` = 00 and `div_code` = 0000, and `bus_ce` is high on every cycle.
- R2: A write (`cfg_we` high at a clock edge) with `cfg_src` equal to 00 (internal), 01 (external) or 10 (PLL) stores that value. It appears on `sel_src` after that edge. `cfg_div` is stored to `div_code` by every write.
- R3: A write with `cfg_src` = 11 leaves `sel_src` and `act_src` unchanged. `sel_src` never shows 11.
- R4: While `act_src` differs from `sel_src`, `act_src` takes the value of `sel_src` at the first clock edge at which the ready input of the selected source is high. Until then it holds its value.
- R5: When `ext_fail` is high at an edge and either `act_src` = 01, or `act_src` = 10 with `pll_from_ext` high, then `sel_src` and `act_src` both become 00 at that edge. In any other case `ext_fail` has no effect.
- R6: When `lp_exit` is high at an edge, `sel_src` becomes 00. This takes priority over a write in the same cycle. `act_src` then follows under R4.
- R7: Divide code decoding: a code with bit 3 clear gives a strobe on every cycle. Codes 1000, 1001, 1010 and 1011 give one strobe every 2, 4, 8 and 16 cycles. Codes 1100, 1101, 1110 and 1111 give one strobe every 64, 128, 256 and 512 cycles.
- R8: A new divide code is applied at the first strobe after the write. That strobe completes the old period, and every later period uses the new divisor.
- R9: `act_src` never shows 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for both configuration fields |
| cfg_src | input | 2 | Requested source (00 internal, 01 external, 10 PLL) |
| cfg_div | input | 4 | Bus divide code |
| rdy_int | input | 1 | Internal oscillator ready |
| rdy_ext | input | 1 | External oscillator ready |
| rdy_pll | input | 1 | PLL locked and ready |
| pll_from_ext | input | 1 | PLL reference is the external oscillator |
| lp_exit | input | 1 | Pulse on leaving a low-power state |
| ext_fail | input | 1 | External oscillator failure detected |
| sel_src | output | 2 | Stored source selection |
| act_src | output | 2 | Source actually clocking the system |
| div_code | output | 4 | Stored divide code |
| bus_ce | output | 1 | Bus clock-enable strobe |

## Verification
The assertions assume that `ext_fail`, `lp_exit` and the ready inputs are synchronous to `clk` and settle before each edge. They judge the override and switch rules against that cycle's port values. The stimulus changes every input on the falling edge, so each value is stable across a full rising edge. Failure and low-power pulses are raised only while the reported source is the one the test targets. The bench changes the divide code only after the previous divisor has had time to take effect.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  typedef enum logic [1:0] {
    SRC_INT = 2'b00,
    SRC_EXT = 2'b01,
    SRC_PLL = 2'b10,
    SRC_BAD = 2'b11
  } src_e;

  localparam int unsigned DIV_CODE_W = 4;
  localparam int unsigned SHIFT_W    = 4;

  // log2 of the bus divisor; the value 32 (shift 5) is never produced
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [DIV_CODE_W-1:0] code);
    logic [SHIFT_W-1:0] low;
    low = {2'b00, code[1:0]};
    if (!code[3])      return '0;
    else if (!code[2]) return low + 4'd1;
    else               return low + 4'd6;
  endfunction

endpackage

// File: rtl/sysclk_sel_reg.sv
module sysclk_sel_reg
  import sysclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_src,
  input  logic       force_int,
  output src_e       sel
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= SRC_INT;
    end else if (force_int) begin
      sel <= SRC_INT;
    end else if (wr_en && (wr_src != SRC_BAD)) begin
      sel <= src_e'(wr_src);
    end
  end

endmodule

// File: rtl/sysclk_src_track.sv
module sysclk_src_track
  import sysclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  src_e sel,
  input  logic rdy_int,
  input  logic rdy_ext,
  input  logic rdy_pll,
  input  logic fail_now,
  output src_e stat
);

  logic tgt_rdy;

  always_comb begin
    case (sel)
      SRC_INT: tgt_rdy = rdy_int;
      SRC_EXT: tgt_rdy = rdy_ext;
      SRC_PLL: tgt_rdy = rdy_pll;
      default: tgt_rdy = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= SRC_INT;
    end else if (fail_now) begin
      stat <= SRC_INT;
    end else if ((stat != sel) && tgt_rdy) begin
      stat <= sel;
    end
  end

endmodule

// File: rtl/sysclk_bus_div.sv
module sysclk_bus_div
  import sysclk_pkg::*;
#(
  parameter int unsigned MAX_SHIFT = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [DIV_CODE_W-1:0] wr_code,
  output logic [DIV_CODE_W-1:0] code_q,
  output logic                  ce
);

  localparam int unsigned CW = MAX_SHIFT;

  logic [DIV_CODE_W-1:0] act_code;
  logic [CW-1:0]         cnt;
  logic [CW:0]           span;
  logic [CW:0]           last_w;

  assign span   = (CW+1)'(1) << div_shift(act_code);
  assign last_w = span - (CW+1)'(1);
  assign ce     = (cnt == last_w[CW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (wr_en) begin
      code_q <= wr_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_code <= '0;
    end else if (ce) begin
      cnt      <= '0;
      act_code <= code_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned MAX_SHIFT = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_src,
  input  logic [3:0] cfg_div,
  input  logic       rdy_int,
  input  logic       rdy_ext,
  input  logic       rdy_pll,
  input  logic       pll_from_ext,
  input  logic       lp_exit,
  input  logic       ext_fail,
  output logic [1:0] sel_src,
  output logic [1:0] act_src,
  output logic [3:0] div_code,
  output logic       bus_ce
);

  src_e sel;
  src_e stat;
  logic fail_now;
  logic force_int;

  assign fail_now  = ext_fail && ((stat == SRC_EXT) || ((stat == SRC_PLL) && pll_from_ext));
  assign force_int = lp_exit || fail_now;

  sysclk_sel_reg u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_src    (cfg_src),
    .force_int (force_int),
    .sel       (sel)
  );

  sysclk_src_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rdy_int  (rdy_int),
    .rdy_ext  (rdy_ext),
    .rdy_pll  (rdy_pll),
    .fail_now (fail_now),
    .stat     (stat)
  );

  sysclk_bus_div #(.MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_code (cfg_div),
    .code_q  (div_code),
    .ce      (bus_ce)
  );

  assign sel_src = sel;
  assign act_src = stat;

endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [1:0] cfg_src,
  input logic [3:0] cfg_div,
  input logic       rdy_int,
  input logic       rdy_ext,
  input logic       rdy_pll,
  input logic       pll_from_ext,
  input logic       lp_exit,
  input logic       ext_fail,
  input logic [1:0] sel_src,
  input logic [1:0] act_src,
  input logic [3:0] div_code,
  input logic       bus_ce
);

  logic fail_c;
  logic want_rdy;

  assign fail_c = ext_fail && ((act_src == 2'b01) || ((act_src == 2'b10) && pll_from_ext));

  always_comb begin
    case (sel_src)
      2'b00:   want_rdy = rdy_int;
      2'b01:   want_rdy = rdy_ext;
      2'b10:   want_rdy = rdy_pll;
      default: want_rdy = 1'b0;
    endcase
  end

  AST_STAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) act_src != 2'b11); // R9
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) sel_src != 2'b11); // R3
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_src != 2'b11) && !lp_exit && !fail_c) |=> (sel_src == $past(cfg_src))); // R2
  AST_HOLD_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_src != act_src) && !want_rdy && !fail_c) |=> (act_src == $past(act_src))); // R4
  AST_FAIL_TO_INT: assert property (@(posedge clk) disable iff (!rst_n)
    fail_c |=> ((sel_src == 2'b00) && (act_src == 2'b00))); // R5
  AST_LP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit |=> (sel_src == 2'b00)); // R6

endmodule

bind sysclk_ctrl sysclk_ctrl_chk u_chk (.*);

// File: tb/sysclk_ctrl_bench.sv
module sysclk_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_src = 2'b00;
  logic [3:0] cfg_div = 4'b0000;
  logic       rdy_int = 1'b1;
  logic       rdy_ext = 1'b0;
  logic       rdy_pll = 1'b0;
  logic       pll_from_ext = 1'b0;
  logic       lp_exit = 1'b0;
  logic       ext_fail = 1'b0;
  logic [1:0] sel_src;
  logic [1:0] act_src;
  logic [3:0] div_code;
  logic       bus_ce;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_ce = 0;
  bit primed = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sysclk_ctrl u_sysclk_ctrl (.*);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops an expected strobe period once a full period is seen
  always @(negedge clk) begin
    if (rst_n && bus_ce) begin
      int gap;
      gap = cyc - last_ce;
      last_ce = cyc;
      if (exp_q.size() > 0) begin
        if (primed) begin
          check(gap == exp_q[0], tag_q[0], gap, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
          primed = 0;
        end else begin
          primed = 1;
        end
      end
    end
  end

  task automatic expect_period(int n, string tag);
    exp_q.push_back(n);
    tag_q.push_back(tag);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_write(logic [1:0] s, logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_src = s; cfg_div = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int ref_div(logic [3:0] c);
    if (!c[3]) return 1;
    case (c[2:0])
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 16;
      3'd4: return 64;
      3'd5: return 128;
      3'd6: return 256;
      default: return 512;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prev;
    int c0;
    int g;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sel_src == 2'b00, "R1 sel", sel_src, 0);
    check(act_src == 2'b00, "R1 act", act_src, 0);
    check(div_code == 4'b0000, "R1 div", div_code, 0);
    check(bus_ce == 1'b1, "R1 ce", bus_ce, 1);

    // external requested but not ready
    do_write(2'b01, 4'b0000);
    check(sel_src == 2'b01, "R2 sel ext", sel_src, 1);
    repeat (3) @(negedge clk);
    check(act_src == 2'b00, "R4 wait ready", act_src, 0);
    rdy_ext = 1'b1;
    @(negedge clk);
    check(act_src == 2'b01, "R4 switch ext", act_src, 1);

    // illegal select ignored
    do_write(2'b11, 4'b0000);
    check(sel_src == 2'b01, "R3 sel kept", sel_src, 1);
    check(act_src == 2'b01, "R3 act kept", act_src, 1);

    // failure while running on external
    ext_fail = 1'b1;
    @(negedge clk);
    ext_fail = 1'b0;
    check(sel_src == 2'b00, "R5 fail sel", sel_src, 0);
    check(act_src == 2'b00, "R5 fail act", act_src, 0);

    // PLL not fed by external: failure has no effect
    rdy_pll = 1'b1;
    do_write(2'b10, 4'b0000);
    check(sel_src == 2'b10, "R2 sel pll", sel_src, 2);
    @(negedge clk);
    check(act_src == 2'b10, "R4 switch pll", act_src, 2);
    ext_fail = 1'b1;
    repeat (3) @(negedge clk);
    ext_fail = 1'b0;
    check(act_src == 2'b10, "R5 ignored act", act_src, 2);
    check(sel_src == 2'b10, "R5 ignored sel", sel_src, 2);
    pll_from_ext = 1'b1;
    ext_fail = 1'b1;
    @(negedge clk);
    ext_fail = 1'b0;
    check(act_src == 2'b00, "R5 pll fail act", act_src, 0);
    check(sel_src == 2'b00, "R5 pll fail sel", sel_src, 0);

    // low-power exit beats a same-cycle write
    do_write(2'b10, 4'b0000);
    @(negedge clk);
    check(act_src == 2'b10, "R4 back to pll", act_src, 2);
    cfg_we = 1'b1; cfg_src = 2'b01; lp_exit = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; lp_exit = 1'b0;
    check(sel_src == 2'b00, "R6 force sel", sel_src, 0);
    @(negedge clk);
    check(act_src == 2'b00, "R6 act follows", act_src, 0);

    // divider codes
    prev = 1;
    for (int i = 0; i < 10; i++) begin
      logic [3:0] c;
      c = (i == 0) ? 4'b0000 : (i == 1) ? 4'b0111 : 4'(4'd8 + 4'(i - 2));
      do_write(2'b00, c);
      check(div_code == c, "R2 div stored", div_code, c);
      repeat (prev + 4) @(negedge clk);
      expect_period(ref_div(c), "R7 period");
      prev = ref_div(c);
    end

    // delayed application
    do_write(2'b00, 4'b1011);
    repeat (520) @(negedge clk);
    while (!bus_ce) @(negedge clk);
    c0 = cyc;
    repeat (5) @(negedge clk);
    do_write(2'b00, 4'b1000);
    while (!bus_ce) @(negedge clk);
    g = cyc - c0;
    check(g == 16, "R8 old period done", g, 16);
    c0 = cyc;
    @(negedge clk);
    while (!bus_ce) @(negedge clk);
    g = cyc - c0;
    check(g == 2, "R8 new period", g, 2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule